// File: doc/BRIEF.md
# Register-to-Register Execute Unit with Status Flags

This block is the execute stage for the register-only arithmetic and logic operations of a small processor with a 16-bit datapath. Each cycle it may accept one operation, given as a 4-bit operation code, the values of the source and destination registers, the index of the destination register, and the current carry and overflow bits. One clock later it presents the result, a write request aimed at the destination register, the new sign, zero, carry and overflow flags, and the number of microcycles the sequencer has to spend on the operation.

The two-register operations are move, add, subtract, compare, AND and XOR. Test and clear are two-register operations with one register used as both operands. The single-register operations are increment, decrement, one's complement, two's complement and add-carry. Compare is a subtract that never writes. A move into the highest register index, the program counter, is reported as a jump. Operations whose destination is one of the two highest register indices take one extra microcycle.

The register file, fetch, decode, memory operands, shifts and branches live in other blocks. The block keeps no architectural state of its own: the flags it produces are returned to the caller, which feeds them back in as the next carry and overflow inputs.

Top module: `reg_alu`

## Requirements
- R1: The outputs are registered with one clock of latency: an accepted operation (in_valid high, code 0 to 12) raises out_valid in the next cycle. Codes 13, 14 and 15 are not operations and give out_valid low in the next cycle with wr_en low.
- R2: Code 0 (move) yields src_val, code 2 (add) yields dst_val + src_val with C the carry out of the top bit, code 5 (AND) and code 6 (XOR) yield the bitwise results; each sets wr_en high with wr_idx equal to dst_idx.
- R3: Code 3 (subtract) yields dst_val + ~src_val + 1, with C the carry out of the top bit (C=1 when no borrow, i.e. dst_val >= src_val unsigned) and OV set on signed overflow of dst_val - src_val. Code 4 (compare) gives the same result and flags with wr_en low.
- R4: Code 1 (test) yields dst_val with the flags of a move, and code 7 (clear) yields zero with the flags of an XOR of a register with itself (S=0, Z=1); both write to dst_idx.
- R5: Code 8 (increment) yields dst_val + 1, code 9 (decrement) yields dst_val - 1, and code 12 (add-carry) yields dst_val + c_in. For each, C is the carry out of the top bit of the addition (for decrement, the addition of all-ones, so C=0 only when dst_val is zero) and OV is set on signed overflow.
- R6: Code 10 (one's complement) yields ~dst_val. Code 11 (negate) yields 0 - dst_val with C=1 only when dst_val is zero; negating the most negative value (0x8000 at the default width) yields that same value with OV=1.
- R7: For every operation, S equals the top bit of the result and Z is 1 exactly when the whole result is zero.
- R8: Move, test, AND, XOR, clear and one's complement leave C and OV equal to the c_in and ov_in presented with the operation.
- R9: cycles is 7 when dst_idx is 6 or 7 and 6 otherwise, for every operation; is_jump is 1 only for a move with dst_idx equal to 7.
- R10: After reset and before the first accepted operation, out_valid, wr_en, is_jump and all flags are 0, result is 0 and cycles is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 4 | Operation code, 0 to 12 |
| src_val | input | WIDTH | Source register value |
| dst_val | input | WIDTH | Destination register value |
| dst_idx | input | IDX_W | Destination register index |
| c_in | input | 1 | Current carry flag |
| ov_in | input | 1 | Current overflow flag |
| out_valid | output | 1 | Result of an accepted operation is present |
| result | output | WIDTH | Operation result |
| wr_en | output | 1 | Request to write result to the register file |
| wr_idx | output | IDX_W | Register index for the write |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_ov | output | 1 | Overflow flag |
| cycles | output | CYC_W | Microcycle count of the operation |
| is_jump | output | 1 | Move into the program counter |

## Verification
The bench builds the unit with WIDTH set to 8 and the register index, cycle and program-counter parameters at their defaults. At that width every destination value can be swept for all single-register and self-operand codes with both carry inputs, and the two-register codes run every destination value against nineteen source values that include zero, one, all-ones and both sides of the sign boundary. This brings every carry-out, borrow and signed-overflow edge, including the negation of the most negative value, within reach of an arithmetic model that works on signed and unsigned integers rather than on bit vectors.

// File: rtl/reg_alu_pkg.sv
package reg_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_MOV = 4'd0,
        OP_TST = 4'd1,
        OP_ADD = 4'd2,
        OP_SUB = 4'd3,
        OP_CMP = 4'd4,
        OP_AND = 4'd5,
        OP_XOR = 4'd6,
        OP_CLR = 4'd7,
        OP_INC = 4'd8,
        OP_DEC = 4'd9,
        OP_COM = 4'd10,
        OP_NEG = 4'd11,
        OP_ADC = 4'd12
    } alu_op_e;

    localparam logic [OP_W-1:0] OP_LAST = 4'd12;

    function automatic logic op_legal(input logic [OP_W-1:0] op);
        return op <= OP_LAST;
    endfunction

    // Operations whose carry and overflow pass through untouched.
    function automatic logic op_keeps_cv(input logic [OP_W-1:0] op);
        return (op == OP_MOV) || (op == OP_TST) || (op == OP_AND) ||
               (op == OP_XOR) || (op == OP_CLR) || (op == OP_COM);
    endfunction

endpackage

// File: rtl/reg_alu_arith.sv
module reg_alu_arith
    import reg_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [OP_W-1:0]  op,
    input  logic [WIDTH-1:0] dst,
    input  logic [WIDTH-1:0] src,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum,
    output logic             c_out,
    output logic             ov_out
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] opa;
    logic [WIDTH-1:0] opb;
    logic             cin;

    // Every arithmetic operation is one pass through a single adder.
    always_comb begin
        opa = dst;
        opb = '0;
        cin = 1'b0;
        case (op)
            OP_ADD: begin
                opb = src;
            end
            OP_SUB, OP_CMP: begin
                opb = ~src;
                cin = 1'b1;
            end
            OP_INC: begin
                cin = 1'b1;
            end
            OP_DEC: begin
                opb = '1;
            end
            OP_NEG: begin
                opa = '0;
                opb = ~dst;
                cin = 1'b1;
            end
            OP_ADC: begin
                cin = c_in;
            end
            default: begin
                opa = dst;
            end
        endcase
    end

    assign {c_out, sum} = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};
    assign ov_out       = (opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB]);

endmodule

// File: rtl/reg_alu_logic.sv
module reg_alu_logic
    import reg_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [OP_W-1:0]  op,
    input  logic [WIDTH-1:0] dst,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] res
);

    always_comb begin
        case (op)
            OP_MOV:  res = src;
            OP_TST:  res = dst;
            OP_AND:  res = dst & src;
            OP_XOR:  res = dst ^ src;
            OP_CLR:  res = dst ^ dst;
            OP_COM:  res = ~dst;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/reg_alu_timing.sv
module reg_alu_timing
    import reg_alu_pkg::*;
#(
    parameter int IDX_W     = 3,
    parameter int SLOW_FROM = 6,
    parameter int PC_IDX    = 7,
    parameter int BASE_CYC  = 6,
    parameter int SLOW_CYC  = 7,
    parameter int CYC_W     = 4
) (
    input  logic [OP_W-1:0]  op,
    input  logic [IDX_W-1:0] dst_idx,
    output logic [CYC_W-1:0] cycles,
    output logic             jump
);

    localparam int NUM_REGS = 1 << IDX_W;

    logic slow;

    generate
        if (SLOW_FROM >= NUM_REGS) begin : g_no_slow
            assign slow = 1'b0;
        end else begin : g_slow
            assign slow = (int'(dst_idx) >= SLOW_FROM);
        end
    endgenerate

    assign cycles = slow ? CYC_W'(SLOW_CYC) : CYC_W'(BASE_CYC);
    assign jump   = (op == OP_MOV) && (int'(dst_idx) == PC_IDX);

endmodule

// File: rtl/reg_alu.sv
module reg_alu
    import reg_alu_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter int IDX_W     = 3,
    parameter int SLOW_FROM = 6,
    parameter int PC_IDX    = 7,
    parameter int BASE_CYC  = 6,
    parameter int SLOW_CYC  = 7,
    parameter int CYC_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  in_op,
    input  logic [WIDTH-1:0] src_val,
    input  logic [WIDTH-1:0] dst_val,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic             c_in,
    input  logic             ov_in,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             flag_s,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_ov,
    output logic [CYC_W-1:0] cycles,
    output logic             is_jump
);

    localparam int MSB = WIDTH - 1;
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] res;
        logic             wr;
        logic [IDX_W-1:0] idx;
        logic             s;
        logic             z;
        logic             c;
        logic             ov;
        logic [CYC_W-1:0] cyc;
        logic             jump;
    } out_t;

    out_t stage_d;
    out_t stage_q;

    logic [WIDTH-1:0] arith_sum;
    logic             arith_c;
    logic             arith_ov;
    logic [WIDTH-1:0] logic_res;
    logic [CYC_W-1:0] op_cycles;
    logic             op_jump;

    reg_alu_arith #(.WIDTH(WIDTH)) u_arith (
        .op     (in_op),
        .dst    (dst_val),
        .src    (src_val),
        .c_in   (c_in),
        .sum    (arith_sum),
        .c_out  (arith_c),
        .ov_out (arith_ov)
    );

    reg_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .op  (in_op),
        .dst (dst_val),
        .src (src_val),
        .res (logic_res)
    );

    reg_alu_timing #(
        .IDX_W     (IDX_W),
        .SLOW_FROM (SLOW_FROM),
        .PC_IDX    (PC_IDX),
        .BASE_CYC  (BASE_CYC),
        .SLOW_CYC  (SLOW_CYC),
        .CYC_W     (CYC_W)
    ) u_timing (
        .op      (in_op),
        .dst_idx (dst_idx),
        .cycles  (op_cycles),
        .jump    (op_jump)
    );

    always_comb begin
        stage_d = '0;
        if (in_valid && op_legal(in_op)) begin
            stage_d.valid = 1'b1;
            if (op_keeps_cv(in_op)) begin
                stage_d.res = logic_res;
                stage_d.c   = c_in;
                stage_d.ov  = ov_in;
            end else begin
                stage_d.res = arith_sum;
                stage_d.c   = arith_c;
                stage_d.ov  = arith_ov;
            end
            stage_d.s    = stage_d.res[MSB];
            stage_d.z    = (stage_d.res == '0);
            stage_d.wr   = (in_op != OP_CMP);
            stage_d.idx  = dst_idx;
            stage_d.cyc  = op_cycles;
            stage_d.jump = op_jump;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.valid;
    assign result    = stage_q.res;
    assign wr_en     = stage_q.wr;
    assign wr_idx    = stage_q.idx;
    assign flag_s    = stage_q.s;
    assign flag_z    = stage_q.z;
    assign flag_c    = stage_q.c;
    assign flag_ov   = stage_q.ov;
    assign cycles    = stage_q.cyc;
    assign is_jump   = stage_q.jump;

    // R1: codes above the last operation are never reported as valid
    p_illegal_dropped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op > OP_LAST)) |=> (!out_valid && !wr_en));

    // R3: compare reports a result but never asks for a write
    p_cmp_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == OP_CMP)) |=> (out_valid && !wr_en));

    // R4: clear always ends at zero with Z set and S clear
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == OP_CLR)) |=> ((result == '0) && flag_z && !flag_s));

    // R6: negating the most negative value overflows onto itself
    p_neg_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == OP_NEG) && (dst_val == MOST_NEG))
        |=> ((result == MOST_NEG) && flag_ov && !flag_c));

    // R8: pass-through operations hand back the incoming carry and overflow
    p_keep_cv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_keeps_cv(in_op))
        |=> ((flag_c == $past(c_in)) && (flag_ov == $past(ov_in))));

    // R9: cycle count follows the destination index of the accepted operation
    p_cycles_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_legal(in_op))
        |=> (cycles == ((int'($past(dst_idx)) >= SLOW_FROM) ?
                        CYC_W'(SLOW_CYC) : CYC_W'(BASE_CYC))));

    // R9: a jump is only ever reported for a move
    p_jump_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op != OP_MOV)) |=> !is_jump);

endmodule

// File: tb/reg_alu_test.sv
module reg_alu_test;

    localparam int TW    = 8;
    localparam int IW    = 3;
    localparam int CW    = 4;
    localparam int MAXU  = (1 << TW) - 1;
    localparam int SMAX  = (1 << (TW - 1)) - 1;
    localparam int SMIN  = -(1 << (TW - 1));

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [3:0]    in_op = '0;
    logic [TW-1:0] src_val = '0;
    logic [TW-1:0] dst_val = '0;
    logic [IW-1:0] dst_idx = '0;
    logic          c_in = 1'b0;
    logic          ov_in = 1'b0;
    logic          out_valid;
    logic [TW-1:0] result;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic          flag_s;
    logic          flag_z;
    logic          flag_c;
    logic          flag_ov;
    logic [CW-1:0] cycles;
    logic          is_jump;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    reg_alu #(.WIDTH(TW), .IDX_W(IW), .CYC_W(CW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_op     (in_op),
        .src_val   (src_val),
        .dst_val   (dst_val),
        .dst_idx   (dst_idx),
        .c_in      (c_in),
        .ov_in     (ov_in),
        .out_valid (out_valid),
        .result    (result),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .flag_s    (flag_s),
        .flag_z    (flag_z),
        .flag_c    (flag_c),
        .flag_ov   (flag_ov),
        .cycles    (cycles),
        .is_jump   (is_jump)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h (op %0d dst 0x%0h src 0x%0h idx %0d)",
                     tag, what, got, exp, in_op, dst_val, src_val, dst_idx);
        end
    endtask

    function automatic string op_tag(input int op);
        case (op)
            0, 2, 5, 6: return "R2";
            3, 4:       return "R3";
            1, 7:       return "R4";
            8, 9, 12:   return "R5";
            default:    return "R6";
        endcase
    endfunction

    function automatic int sx(input int v);
        return (v > SMAX) ? v - (MAXU + 1) : v;
    endfunction

    // Drive at a falling edge, let the rising edge capture, check at the next falling edge.
    task automatic run_op(input int op, input int d, input int s, input int idx, input bit ci, input bit oi);
        int  u;
        int  si;
        int  r;
        bit  ec;
        bit  eov;
        bit  keep;
        in_valid = 1'b1;
        in_op    = 4'(op);
        dst_val  = TW'(d);
        src_val  = TW'(s);
        dst_idx  = IW'(idx);
        c_in     = ci;
        ov_in    = oi;
        keep = 1'b0;
        u = 0;
        si = 0;
        case (op)
            0:  begin keep = 1'b1; r = s; end
            1:  begin keep = 1'b1; r = d; end
            2:  begin u = d + s;            si = sx(d) + sx(s); end
            3, 4: begin u = d + (MAXU - s) + 1; si = sx(d) - sx(s); end
            5:  begin keep = 1'b1; r = d & s; end
            6:  begin keep = 1'b1; r = d ^ s; end
            7:  begin keep = 1'b1; r = 0; end
            8:  begin u = d + 1;            si = sx(d) + 1; end
            9:  begin u = d + MAXU;         si = sx(d) - 1; end
            10: begin keep = 1'b1; r = MAXU - d; end
            11: begin u = (MAXU - d) + 1;   si = -sx(d); end
            default: begin u = d + int'(ci); si = sx(d) + int'(ci); end
        endcase
        if (keep) begin
            ec  = ci;
            eov = oi;
        end else begin
            r   = u % (MAXU + 1);
            ec  = (u > MAXU);
            eov = (si > SMAX) || (si < SMIN);
        end
        @(negedge clk);
        check(op_tag(op), "valid", int'(out_valid), 1);
        check(op_tag(op), "result", int'(result), r);
        check(op_tag(op), "wr_en", int'(wr_en), (op == 4) ? 0 : 1);
        check(op_tag(op), "wr_idx", int'(wr_idx), idx);
        check("R7", "flag_s", int'(flag_s), (r > SMAX) ? 1 : 0);
        check("R7", "flag_z", int'(flag_z), (r == 0) ? 1 : 0);
        check(keep ? "R8" : op_tag(op), "flag_c", int'(flag_c), int'(ec));
        check(keep ? "R8" : op_tag(op), "flag_ov", int'(flag_ov), int'(eov));
        check("R9", "cycles", int'(cycles), (idx >= 6) ? 7 : 6);
        check("R9", "is_jump", int'(is_jump), (op == 0 && idx == 7) ? 1 : 0);
    endtask

    task automatic run_illegal(input int op);
        in_valid = 1'b1;
        in_op    = 4'(op);
        dst_val  = '1;
        src_val  = '1;
        dst_idx  = '1;
        @(negedge clk);
        check("R1", "valid_illegal", int'(out_valid), 0);
        check("R1", "wr_illegal", int'(wr_en), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values
        check("R10", "valid", int'(out_valid), 0);
        check("R10", "result", int'(result), 0);
        check("R10", "wr_en", int'(wr_en), 0);
        check("R10", "flags", int'({flag_s, flag_z, flag_c, flag_ov}), 0);
        check("R10", "cycles", int'(cycles), 0);
        check("R10", "is_jump", int'(is_jump), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle input keeps the output invalid
        check("R1", "valid_idle", int'(out_valid), 0);

        // R6: directed negate of the most negative value
        run_op(11, 1 << (TW - 1), 0, 2, 1'b0, 1'b0);
        check("R6", "neg_min_ov", int'(flag_ov), 1);
        // R3: borrow case 0 - 1
        run_op(3, 0, 1, 0, 1'b1, 1'b0);
        check("R3", "borrow_c", int'(flag_c), 0);
        // R9: move into the program counter
        run_op(0, 5, 77, 7, 1'b0, 1'b0);
        check("R9", "jump_pc", int'(is_jump), 1);

        // Two-register operations: every dst against a spread of sources
        for (int k = 0; k < 6; k++) begin
            int op;
            op = (k == 0) ? 0 : (k == 1) ? 2 : (k == 2) ? 3 :
                 (k == 3) ? 4 : (k == 4) ? 5 : 6;
            for (int d = 0; d <= MAXU; d++) begin
                for (int j = 0; j < 19; j++) begin
                    int s;
                    s = (j < 16) ? j * 17 : (j == 16) ? 1 : (j == 17) ? SMAX : SMAX + 1;
                    run_op(op, d, s, d % 8, bit'(d ^ s), bit'(s >> 1));
                end
            end
        end

        // Self-operand and single-register operations: every dst, both carries
        for (int k = 0; k < 7; k++) begin
            int op;
            op = (k == 0) ? 1 : (k == 1) ? 7 : (k + 6);
            for (int d = 0; d <= MAXU; d++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    run_op(op, d, MAXU - d, (d + ci) % 8, bit'(ci), bit'(d >> 2));
                end
            end
        end

        // R1: codes beyond the operation set
        for (int op = 13; op < 16; op++) begin
            run_illegal(op);
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R1", "valid_after_idle", int'(out_valid), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule